// File: doc/BRIEF.md
# SPI Status Flag and Interrupt Unit

This block keeps the status side of an SPI peripheral that moves either 8-bit or 16-bit words. A separate shift engine tells it when a transfer has finished (with the word it shifted in), when it has taken the buffered transmit word, and when it has seen a fault on the slave-select pin. The block stores the received word, keeps four flags (receive full, transmit empty, mode fault and match), and combines them through three enable masks into a single interrupt request.

Software reaches the block through a small byte-wide register bus. Each flag is cleared by a two-step sequence. The first step is a status read taken while the flag is set. The second step is an access that depends on the flag. A received word that arrives while the receive-full flag is still set is thrown away, so the buffer keeps the older word. A mode fault takes the block out of master mode and sends a one-cycle abort strobe to the shift engine.

Top module: `spi_stat_irq`

## Requirements
- R1: `irq` is 0 in every cycle that follows a cycle in which the enable bit (CTRL_A bit 0) was 0.
- R2: `irq` is registered and goes high one cycle after one of these terms is true while the block is enabled: receive-full or mode-fault with the receive mask (CTRL_A bit 1), transmit-empty with the transmit mask (CTRL_A bit 2), or match with the match mask (CTRL_B bit 0, address 1).
- R3: A `xfer_done` pulse that is accepted sets receive-full (STATUS bit 0, address 2). In 16-bit mode (CTRL_A bit 4 = 1) the whole word goes into DATA_HI (address 3) and DATA_LO (address 4). In 8-bit mode only bits 7:0 go into DATA_LO, and DATA_HI keeps its old value.
- R4: Receive-full clears only after two steps in this order: a STATUS read while the flag is set, then a DATA_LO read. A DATA_LO read without that earlier status read leaves the flag set.
- R5: A `xfer_done` pulse that arrives while receive-full is set is ignored. The flag stays set and the buffer keeps the earlier word.
- R6: `mf_det` sets mode-fault (STATUS bit 2) when it arrives while the block is enabled and in master mode (CTRL_A bit 3). At the same time it clears the master bit and pulses `abort` high for exactly one cycle. `mf_det` has no effect when the block is not in master mode.
- R7: Mode-fault, and with it its request, stays set until two steps happen in this order: a STATUS read while the flag is set, then a write to CTRL_A (address 0).
- R8: Transmit-empty (STATUS bit 1) is 1 after reset. It clears after a STATUS read while the flag is set followed by a DATA_LO write, and it sets again on `tx_load`. The bytes written to DATA_HI and DATA_LO appear on `tx_word`.
- R9: Match (STATUS bit 3) sets when an accepted word equals MATCH_HI:MATCH_LO (addresses 5 and 6). In 8-bit mode only the low byte is compared. The flag clears after a STATUS read while it is set followed by a STATUS write with bit 3 = 1.
- R10: After reset, DATA_HI and DATA_LO read 0, STATUS reads 8'h02, and `irq`, `master` and `abort` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered, valid the cycle after `bus_rd` |
| xfer_done | input | 1 | Transfer-complete pulse from the shift engine |
| xfer_word | input | 16 | Word shifted in, valid with `xfer_done` |
| tx_load | input | 1 | Shift engine has taken the buffered transmit word |
| mf_det | input | 1 | Fault seen on the slave-select pin |
| tx_word | output | 16 | Buffered transmit word |
| irq | output | 1 | Combined interrupt request |
| master | output | 1 | Master-mode control bit |
| abort | output | 1 | One-cycle transfer-abort strobe |

## Verification
The assertions assume that each of `xfer_done`, `tx_load` and `mf_det` is a one-cycle pulse, and that a flag-clearing access never arrives in the same cycle as an event that sets that flag. The stimulus keeps to this. Every strobe is driven for exactly one cycle between falling edges, and bus accesses and shift-engine events never share a cycle. Overrun is tested with two back-to-back transfers, with no status read between them. The mode fault is raised only after master mode has been set by a CTRL_A write.

// File: rtl/spi_stat_pkg.sv
package spi_stat_pkg;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_CTRL_A  = 3'd0;
  localparam logic [ADDR_W-1:0] A_CTRL_B  = 3'd1;
  localparam logic [ADDR_W-1:0] A_STATUS  = 3'd2;
  localparam logic [ADDR_W-1:0] A_DATA_HI = 3'd3;
  localparam logic [ADDR_W-1:0] A_DATA_LO = 3'd4;
  localparam logic [ADDR_W-1:0] A_MATCH_HI = 3'd5;
  localparam logic [ADDR_W-1:0] A_MATCH_LO = 3'd6;

  // CTRL_A bit positions
  localparam int B_EN     = 0;
  localparam int B_RX_IE  = 1;
  localparam int B_TX_IE  = 2;
  localparam int B_MASTER = 3;
  localparam int B_WIDE   = 4;

  // STATUS bit positions
  localparam int S_RX_FULL  = 0;
  localparam int S_TX_EMPTY = 1;
  localparam int S_MFAULT   = 2;
  localparam int S_MATCH    = 3;

  typedef struct packed {
    logic wr_ca;
    logic wr_cb;
    logic wr_st;
    logic wr_dh;
    logic wr_dl;
    logic wr_mh;
    logic wr_ml;
    logic rd_st;
    logic rd_dl;
  } bus_stb_t;
endpackage

// File: rtl/spi_cfg_regs.sv
module spi_cfg_regs
  import spi_stat_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_stb_t          stb,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              mf_set,
  output logic              en,
  output logic              rx_ie,
  output logic              tx_ie,
  output logic              wide,
  output logic              m_ie,
  output logic              master,
  output logic [DATA_W-1:0] match_val
);
  always_ff @(posedge clk) begin
    if (rst) begin
      en        <= 1'b0;
      rx_ie     <= 1'b0;
      tx_ie     <= 1'b0;
      wide      <= 1'b0;
      m_ie      <= 1'b0;
      match_val <= '0;
    end else begin
      if (stb.wr_ca) begin
        en    <= wdata[B_EN];
        rx_ie <= wdata[B_RX_IE];
        tx_ie <= wdata[B_TX_IE];
        wide  <= wdata[B_WIDE];
      end
      if (stb.wr_cb) m_ie <= wdata[0];
      if (stb.wr_mh) match_val[DATA_W-1:BYTE_W] <= wdata;
      if (stb.wr_ml) match_val[BYTE_W-1:0] <= wdata;
    end
  end

  // A mode fault wins over a control write in the same cycle.
  always_ff @(posedge clk) begin
    if (rst)            master <= 1'b0;
    else if (mf_set)    master <= 1'b0;
    else if (stb.wr_ca) master <= wdata[B_MASTER];
  end

  p_master_drop_r6: assert property (@(posedge clk) disable iff (rst)
    mf_set |=> !master);
endmodule

// File: rtl/spi_rx_unit.sv
module spi_rx_unit
  import spi_stat_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_stb_t          stb,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              wide,
  input  logic [DATA_W-1:0] match_val,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_word,
  output logic [DATA_W-1:0] rx_buf,
  output logic              rx_full,
  output logic              match
);
  logic rx_arm, m_arm;
  logic store, hit, rx_clr, m_clr;

  assign store  = xfer_done & ~rx_full;
  assign hit    = wide ? (xfer_word == match_val)
                       : (xfer_word[BYTE_W-1:0] == match_val[BYTE_W-1:0]);
  assign rx_clr = rx_full & rx_arm & stb.rd_dl;
  assign m_clr  = match & m_arm & stb.wr_st & wdata[S_MATCH];

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_buf <= '0;
    end else if (store) begin
      rx_buf[BYTE_W-1:0] <= xfer_word[BYTE_W-1:0];
      if (wide) rx_buf[DATA_W-1:BYTE_W] <= xfer_word[DATA_W-1:BYTE_W];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rx_full <= 1'b0;
      rx_arm  <= 1'b0;
    end else if (store) begin
      rx_full <= 1'b1;
    end else if (rx_clr) begin
      rx_full <= 1'b0;
      rx_arm  <= 1'b0;
    end else if (stb.rd_st && rx_full) begin
      rx_arm  <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      match <= 1'b0;
      m_arm <= 1'b0;
    end else if (store && hit) begin
      match <= 1'b1;
    end else if (m_clr) begin
      match <= 1'b0;
      m_arm <= 1'b0;
    end else if (stb.rd_st && match) begin
      m_arm <= 1'b1;
    end
  end

  p_rx_full_held_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_full && !stb.rd_dl) |=> rx_full);
  p_drop_keeps_buf_r5: assert property (@(posedge clk) disable iff (rst)
    (rx_full && xfer_done) |=> $stable(rx_buf));
  p_match_held_r9: assert property (@(posedge clk) disable iff (rst)
    (match && !stb.wr_st) |=> match);
endmodule

// File: rtl/spi_txmf_unit.sv
module spi_txmf_unit
  import spi_stat_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  bus_stb_t          stb,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              en,
  input  logic              master,
  input  logic              tx_load,
  input  logic              mf_det,
  output logic              mf_set,
  output logic              mfault,
  output logic              tx_empty,
  output logic [DATA_W-1:0] tx_buf,
  output logic              abort
);
  logic tx_arm, mf_arm;
  logic tx_clr, mf_clr;

  assign mf_set = mf_det & master & en;
  assign tx_clr = tx_empty & tx_arm & stb.wr_dl;
  assign mf_clr = mfault & mf_arm & stb.wr_ca;

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_buf <= '0;
    end else begin
      if (stb.wr_dh) tx_buf[DATA_W-1:BYTE_W] <= wdata;
      if (stb.wr_dl) tx_buf[BYTE_W-1:0] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      tx_empty <= 1'b1;
      tx_arm   <= 1'b0;
    end else if (tx_load) begin
      tx_empty <= 1'b1;
    end else if (tx_clr) begin
      tx_empty <= 1'b0;
      tx_arm   <= 1'b0;
    end else if (stb.rd_st && tx_empty) begin
      tx_arm   <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mfault <= 1'b0;
      mf_arm <= 1'b0;
      abort  <= 1'b0;
    end else begin
      abort <= mf_set;
      if (mf_set) begin
        mfault <= 1'b1;
      end else if (mf_clr) begin
        mfault <= 1'b0;
        mf_arm <= 1'b0;
      end else if (stb.rd_st && mfault) begin
        mf_arm <= 1'b1;
      end
    end
  end

  p_abort_single_r6: assert property (@(posedge clk) disable iff (rst)
    abort |=> !abort);
  p_mf_held_r7: assert property (@(posedge clk) disable iff (rst)
    (mfault && !stb.wr_ca) |=> mfault);
  p_tx_reload_r8: assert property (@(posedge clk) disable iff (rst)
    tx_load |=> tx_empty);
endmodule

// File: rtl/spi_irq_gen.sv
module spi_irq_gen (
  input  logic clk,
  input  logic rst,
  input  logic en,
  input  logic rx_ie,
  input  logic tx_ie,
  input  logic m_ie,
  input  logic rx_full,
  input  logic mfault,
  input  logic tx_empty,
  input  logic match,
  output logic irq
);
  logic req;

  assign req = en & ((rx_ie & (rx_full | mfault)) |
                     (tx_ie & tx_empty) |
                     (m_ie & match));

  always_ff @(posedge clk) begin
    if (rst) irq <= 1'b0;
    else     irq <= req;
  end

  p_quiet_when_off_r1: assert property (@(posedge clk) disable iff (rst)
    !en |=> !irq);
  p_mf_request_r7: assert property (@(posedge clk) disable iff (rst)
    (en && rx_ie && mfault) |=> irq);
  p_tx_request_r2: assert property (@(posedge clk) disable iff (rst)
    (en && tx_ie && tx_empty) |=> irq);
endmodule

// File: rtl/spi_stat_irq.sv
module spi_stat_irq
  import spi_stat_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [BYTE_W-1:0] bus_wdata,
  output logic [BYTE_W-1:0] bus_rdata,
  input  logic              xfer_done,
  input  logic [DATA_W-1:0] xfer_word,
  input  logic              tx_load,
  input  logic              mf_det,
  output logic [DATA_W-1:0] tx_word,
  output logic              irq,
  output logic              master,
  output logic              abort
);
  bus_stb_t          stb;
  logic              en, rx_ie, tx_ie, wide, m_ie;
  logic [DATA_W-1:0] match_val, rx_buf;
  logic              rx_full, match, mfault, tx_empty, mf_set;
  logic [BYTE_W-1:0] status_byte, ctrl_a_byte;

  always_comb begin
    stb.wr_ca = bus_wr && (bus_addr == A_CTRL_A);
    stb.wr_cb = bus_wr && (bus_addr == A_CTRL_B);
    stb.wr_st = bus_wr && (bus_addr == A_STATUS);
    stb.wr_dh = bus_wr && (bus_addr == A_DATA_HI);
    stb.wr_dl = bus_wr && (bus_addr == A_DATA_LO);
    stb.wr_mh = bus_wr && (bus_addr == A_MATCH_HI);
    stb.wr_ml = bus_wr && (bus_addr == A_MATCH_LO);
    stb.rd_st = bus_rd && (bus_addr == A_STATUS);
    stb.rd_dl = bus_rd && (bus_addr == A_DATA_LO);
  end

  spi_cfg_regs #(.BYTE_W(BYTE_W)) u_cfg (
    .clk(clk), .rst(rst), .stb(stb), .wdata(bus_wdata), .mf_set(mf_set),
    .en(en), .rx_ie(rx_ie), .tx_ie(tx_ie), .wide(wide), .m_ie(m_ie),
    .master(master), .match_val(match_val)
  );

  spi_rx_unit #(.BYTE_W(BYTE_W)) u_rx (
    .clk(clk), .rst(rst), .stb(stb), .wdata(bus_wdata), .wide(wide),
    .match_val(match_val), .xfer_done(xfer_done), .xfer_word(xfer_word),
    .rx_buf(rx_buf), .rx_full(rx_full), .match(match)
  );

  spi_txmf_unit #(.BYTE_W(BYTE_W)) u_txmf (
    .clk(clk), .rst(rst), .stb(stb), .wdata(bus_wdata), .en(en),
    .master(master), .tx_load(tx_load), .mf_det(mf_det), .mf_set(mf_set),
    .mfault(mfault), .tx_empty(tx_empty), .tx_buf(tx_word), .abort(abort)
  );

  spi_irq_gen u_irq (
    .clk(clk), .rst(rst), .en(en), .rx_ie(rx_ie), .tx_ie(tx_ie),
    .m_ie(m_ie), .rx_full(rx_full), .mfault(mfault), .tx_empty(tx_empty),
    .match(match), .irq(irq)
  );

  always_comb begin
    status_byte = '0;
    status_byte[S_RX_FULL]  = rx_full;
    status_byte[S_TX_EMPTY] = tx_empty;
    status_byte[S_MFAULT]   = mfault;
    status_byte[S_MATCH]    = match;
    ctrl_a_byte = '0;
    ctrl_a_byte[B_EN]     = en;
    ctrl_a_byte[B_RX_IE]  = rx_ie;
    ctrl_a_byte[B_TX_IE]  = tx_ie;
    ctrl_a_byte[B_MASTER] = master;
    ctrl_a_byte[B_WIDE]   = wide;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_rd) begin
      case (bus_addr)
        A_CTRL_A:   bus_rdata <= ctrl_a_byte;
        A_CTRL_B:   bus_rdata <= {{(BYTE_W-1){1'b0}}, m_ie};
        A_STATUS:   bus_rdata <= status_byte;
        A_DATA_HI:  bus_rdata <= rx_buf[DATA_W-1:BYTE_W];
        A_DATA_LO:  bus_rdata <= rx_buf[BYTE_W-1:0];
        A_MATCH_HI: bus_rdata <= match_val[DATA_W-1:BYTE_W];
        A_MATCH_LO: bus_rdata <= match_val[BYTE_W-1:0];
        default:    bus_rdata <= '0;
      endcase
    end
  end

  p_abort_leaves_master_r6: assert property (@(posedge clk) disable iff (rst)
    abort |-> !master);
endmodule

// File: tb/spi_stat_irq_test.sv
`timescale 1ns/1ps
module spi_stat_irq_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [2:0]  bus_addr = '0;
  logic [7:0]  bus_wdata = '0;
  logic [7:0]  bus_rdata;
  logic        xfer_done = 1'b0;
  logic [15:0] xfer_word = '0;
  logic        tx_load = 1'b0, mf_det = 1'b0;
  logic [15:0] tx_word;
  logic        irq, master, abort;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;
  logic [7:0] rv;

  always #4 clk = ~clk;

  spi_stat_irq uut (
    .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .xfer_done(xfer_done), .xfer_word(xfer_word), .tx_load(tx_load),
    .mf_det(mf_det), .tx_word(tx_word), .irq(irq), .master(master),
    .abort(abort)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_rd = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_rd = 1'b0;
    d = bus_rdata;
  endtask

  task automatic xfer(input logic [15:0] w);
    xfer_done = 1'b1; xfer_word = w;
    @(negedge clk);
    xfer_done = 1'b0;
  endtask

  // wide, word, match, exp_lo, exp_hi, exp_match
  localparam logic [49:0] VEC [6] = '{
    {1'b1, 16'hA55A, 16'hA55A, 8'h5A, 8'hA5, 1'b1},
    {1'b1, 16'h1234, 16'h1235, 8'h34, 8'h12, 1'b0},
    {1'b0, 16'hBE77, 16'h0077, 8'h77, 8'h12, 1'b1},
    {1'b0, 16'h00C3, 16'h00C4, 8'hC3, 8'h12, 1'b0},
    {1'b1, 16'hFFFF, 16'h0000, 8'hFF, 8'hFF, 1'b0},
    {1'b0, 16'h1200, 16'hFF00, 8'h00, 8'hFF, 1'b1}
  };

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R10 reset state
    chk("R10 irq", irq, 0);
    chk("R10 master", master, 0);
    chk("R10 abort", abort, 0);
    rd(3'd2, rv); chk("R10 status", rv, 8'h02);
    rd(3'd3, rv); chk("R10 data_hi", rv, 8'h00);
    rd(3'd4, rv); chk("R10 data_lo", rv, 8'h00);

    // R1: transmit mask set but block disabled
    wr(3'd0, 8'h04);
    repeat (2) @(negedge clk);
    chk("R1 no irq while disabled", irq, 0);
    wr(3'd0, 8'h05);
    @(negedge clk);
    chk("R2 tx mask irq", irq, 1);
    wr(3'd0, 8'h03);
    @(negedge clk);
    chk("R2 rx mask alone no irq", irq, 0);

    // Vector table: R3, R4, R9
    wr(3'd1, 8'h01);
    for (int i = 0; i < 6; i++) begin
      logic [49:0] v;
      v = VEC[i];
      wr(3'd0, {3'b0, v[49], 4'b0001});
      wr(3'd5, v[32:25]);
      wr(3'd6, v[24:17]);
      xfer(v[48:33]);
      rd(3'd2, rv);
      chk("R3 rx_full set", rv[0], 1);
      chk("R9 match flag", rv[3], v[0]);
      chk("R2 match irq", irq, v[0]);
      rd(3'd3, rv); chk("R3 data_hi", rv, v[8:1]);
      rd(3'd4, rv); chk("R3 data_lo", rv, v[16:9]);
      wr(3'd2, 8'h08);
      rd(3'd2, rv);
      chk("R4 rx_full cleared", rv[0], 0);
      chk("R9 match cleared", rv[3], 0);
    end
    wr(3'd1, 8'h00);

    // R9: write-1 without a prior status read does not clear
    wr(3'd0, 8'h11);
    wr(3'd5, 8'h55); wr(3'd6, 8'h66);
    xfer(16'h5566);
    wr(3'd2, 8'h08);
    rd(3'd2, rv); chk("R9 match kept without arm", rv[3], 1);
    wr(3'd2, 8'h08);
    rd(3'd4, rv);
    rd(3'd2, rv); chk("R9 match cleared after arm", rv[3], 0);
    chk("R4 rx cleared after arm", rv[0], 0);

    // R4: data read without status read keeps the flag
    xfer(16'h0F0E);
    rd(3'd4, rv); chk("R4 lo read", rv, 8'h0E);
    rd(3'd2, rv); chk("R4 flag kept without arm", rv[0], 1);
    rd(3'd4, rv);
    rd(3'd2, rv); chk("R4 flag cleared", rv[0], 0);

    // R5: overrun drops the second word
    xfer(16'h1111);
    xfer(16'h2222);
    rd(3'd2, rv); chk("R5 flag still set", rv[0], 1);
    rd(3'd3, rv); chk("R5 hi kept", rv, 8'h11);
    rd(3'd4, rv); chk("R5 lo kept", rv, 8'h11);
    xfer(16'h3333);
    rd(3'd2, rv);
    rd(3'd4, rv); chk("R5 later word accepted", rv, 8'h33);

    // R6: mode fault ignored when not master
    mf_det = 1'b1; @(negedge clk); mf_det = 1'b0;
    rd(3'd2, rv); chk("R6 no fault without master", rv[2], 0);

    // R6/R7: mode fault in master mode
    wr(3'd0, 8'h0B);
    chk("R6 master set", master, 1);
    mf_det = 1'b1; @(negedge clk); mf_det = 1'b0;
    chk("R6 abort pulse", abort, 1);
    chk("R6 master cleared", master, 0);
    @(negedge clk);
    chk("R6 abort single", abort, 0);
    chk("R7 fault irq", irq, 1);
    wr(3'd0, 8'h03);
    rd(3'd2, rv); chk("R7 fault kept without arm", rv[2], 1);
    chk("R7 irq held", irq, 1);
    wr(3'd0, 8'h03);
    rd(3'd2, rv); chk("R7 fault cleared", rv[2], 0);
    chk("R7 irq dropped", irq, 0);

    // R8: transmit buffer
    rd(3'd2, rv); chk("R8 tx_empty before", rv[1], 1);
    wr(3'd3, 8'hAB);
    wr(3'd4, 8'hCD);
    chk("R8 tx_word", tx_word, 16'hABCD);
    rd(3'd2, rv); chk("R8 tx_empty cleared", rv[1], 0);
    tx_load = 1'b1; @(negedge clk); tx_load = 1'b0;
    rd(3'd2, rv); chk("R8 tx_empty reloaded", rv[1], 1);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #800000;
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule